// File: doc/BRIEF.md
# Audio serial clock generator

This block produces the bit clock and the frame (left/right) clock of a stereo serial audio port from the module clock, together with the one-cycle strobes a downstream shifter needs to place its data. A single control word selects master or slave operation, the polarity of each of the two clocks on its own, a 4-bit bit-clock divider code, a 3-bit frame-length code, the word size and the framing format.

As master, the block divides the module clock by a ratio picked from a fixed table (1 to 192, not all powers of two), counts bit periods into frames of 16 to 256 bits, drives both clocks and pulses a bit strobe at the start of every bit period, a frame strobe at each frame start and a channel strobe at each half-frame. As slave, it synchronises externally supplied clocks, finds the active edges and produces the same strobes. The control word is registered, so every setting takes effect one module clock after it is applied. A change of the divider or frame-length field restarts both counters, so no short period is emitted.

Top module: `aud_sclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `clk_oe`, `bclk_o`, `fclk_o`, `bit_stb`, `frame_stb` and `chan_stb` are all 0.
- R2: The control word fields are: bit 15 master, bit 14 bit-clock inversion, bit 13 frame-clock inversion, bits 12:9 divider code, bits 8:6 frame-length code, bits 5:4 word size, bits 3:2 format (0 = I2S, 1 = left-justified, 2 = right-justified, 3 = DSP). `word16_o` is 1 exactly when the word-size code is 1 and `fmt_o` equals the format field, both one cycle after the control word is applied.
- R3: In master mode divider codes 0..13 give ratios R = 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 192. For R ≥ 2 each bit period lasts R module clocks, the uninverted bit clock is low for the first R/2 and high for the last R/2, and `bit_stb` is 1 in the first cycle of each period.
- R4: With ratio 1 the uninverted bit clock is the module clock itself and `bit_stb` is 1 in every cycle.
- R5: A frame has N = 16·2^code bit periods (codes 0..4); the uninverted frame clock is low for bits 0..N/2-1 and high for bits N/2..N-1.
- R6: For formats other than I2S, `frame_stb` is 1 in the first cycle of bit 0 and `chan_stb` in the first cycle of bit N/2.
- R7: In I2S format both strobes come one bit period later: bit 1 and bit N/2+1.
- R8: Bit 14 inverts only `bclk_o` and bit 13 only `fclk_o`.
- R9: In master mode, divider codes 14 and 15 and frame-length codes 5..7 hold `bclk_o` at the value of bit 14 and `fclk_o` at the value of bit 13, with no strobes.
- R10: After a change of the divider or frame-length field, the first cycle with the new setting is the first cycle of bit 0 of a new frame.
- R11: In slave mode `bit_stb` pulses once for each falling edge of the external bit clock (after inversion) within three module clocks; a falling edge of the (inverted-as-configured) external frame clock seen at a bit strobe gives `frame_stb` and a rising one gives `chan_stb`, at that strobe for non-I2S formats and at the next bit strobe in I2S.
- R12: `clk_oe` equals the master bit one cycle after it is applied; with `clk_oe` at 0, `bclk_o` and `fclk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl | input | 14 | Control word bits 15:2 |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_fclk | input | 1 | External frame clock (slave mode) |
| clk_oe | output | 1 | Clock outputs driven (master) |
| bclk_o | output | 1 | Bit clock out |
| fclk_o | output | 1 | Frame clock out |
| bit_stb | output | 1 | Start of a bit period |
| frame_stb | output | 1 | Frame start strobe |
| chan_stb | output | 1 | Channel boundary strobe |
| word16_o | output | 1 | 16-bit word size selected |
| fmt_o | output | 2 | Selected framing format |

## Verification
A wrong divider count shows as a bit clock whose high or low phase has the wrong length, visible at the first mismatched period, at most 192 module clocks after a restart. A wrong bit counter shows as a frame clock edge or strobe at the wrong bit index, visible within one frame of up to 256 bit periods. A counter that fails to clear on a field change shows at once, because the very next cycle must carry a bit strobe with the frame clock low. In slave mode, a broken edge detector or pending flag shows as a missing, doubled or misplaced strobe at the next external edge.

// File: rtl/asg_pkg.sv
package asg_pkg;

    localparam int RATIO_W = 8;
    localparam int FRAME_W = 9;
    localparam logic [2:0] FLEN_MAX = 3'd4;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2,
        FMT_DSP   = 2'd3
    } fmt_e;

    // Field order matches control bits 15:2.
    typedef struct packed {
        logic       master;
        logic       binv;
        logic       finv;
        logic [3:0] div;
        logic [2:0] flen;
        logic [1:0] wsz;
        logic [1:0] fmt;
    } cfg_t;

    function automatic logic [RATIO_W-1:0] ratio_of(input logic [3:0] code);
        case (code)
            4'd0:    return RATIO_W'(1);
            4'd1:    return RATIO_W'(2);
            4'd2:    return RATIO_W'(4);
            4'd3:    return RATIO_W'(6);
            4'd4:    return RATIO_W'(8);
            4'd5:    return RATIO_W'(12);
            4'd6:    return RATIO_W'(16);
            4'd7:    return RATIO_W'(24);
            4'd8:    return RATIO_W'(32);
            4'd9:    return RATIO_W'(48);
            4'd10:   return RATIO_W'(64);
            4'd11:   return RATIO_W'(96);
            4'd12:   return RATIO_W'(128);
            4'd13:   return RATIO_W'(192);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/asg_bitclk.sv
module asg_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick,
    output logic             last,
    output logic             lvl
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             lvl;
    } bc_st_t;

    bc_st_t st_d, st_q;
    logic [DIV_W-1:0] half;

    assign half = ratio >> 1;
    assign tick = run && (st_q.cnt == '0);
    assign last = run && (st_q.cnt == ratio - 1'b1);
    assign lvl  = st_q.lvl;

    always_comb begin
        st_d = st_q;
        if (!run || clr || last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.lvl = (run && !clr) ? (st_d.cnt >= half) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/asg_framer.sv
module asg_framer #(
    parameter int FRM_W = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       clr,
    input  logic       tick,
    input  logic       last,
    input  logic [2:0] flen,
    input  logic       i2s,
    output logic       lvl,
    output logic       frame_stb,
    output logic       chan_stb
);
    typedef struct packed {
        logic [FRM_W-1:0] bitn;
        logic             lvl;
    } fr_st_t;

    fr_st_t st_d, st_q;
    logic [FRM_W-1:0] nbits, half, offs;

    assign nbits = FRM_W'(16) << flen;
    assign half  = nbits >> 1;
    assign offs  = FRM_W'(i2s);

    assign lvl       = st_q.lvl;
    assign frame_stb = tick && (st_q.bitn == offs);
    assign chan_stb  = tick && (st_q.bitn == half + offs);

    always_comb begin
        st_d = st_q;
        if (!run || clr) begin
            st_d.bitn = '0;
        end else if (last) begin
            st_d.bitn = (st_q.bitn == nbits - 1'b1) ? '0 : st_q.bitn + 1'b1;
        end
        st_d.lvl = (run && !clr) ? (st_d.bitn >= half) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/asg_slave_rx.sv
module asg_slave_rx (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_b,
    input  logic ext_f,
    input  logic binv,
    input  logic finv,
    input  logic i2s,
    output logic tick,
    output logic frame_stb,
    output logic chan_stb
);
    typedef struct packed {
        logic [1:0] bsync;
        logic [1:0] fsync;
        logic       bprev;
        logic       fref;
        logic       pend_f;
        logic       pend_c;
    } sl_st_t;

    sl_st_t st_d, st_q;
    logic b_s, f_s, chg;

    assign b_s  = st_q.bsync[1] ^ binv;
    assign f_s  = st_q.fsync[1] ^ finv;
    assign tick = st_q.bprev && !b_s;
    assign chg  = tick && (f_s != st_q.fref);

    assign frame_stb = i2s ? (tick && st_q.pend_f) : (chg && !f_s);
    assign chan_stb  = i2s ? (tick && st_q.pend_c) : (chg && f_s);

    always_comb begin
        st_d       = st_q;
        st_d.bsync = {st_q.bsync[0], ext_b};
        st_d.fsync = {st_q.fsync[0], ext_f};
        st_d.bprev = b_s;
        if (tick) begin
            st_d.fref   = f_s;
            st_d.pend_f = i2s && chg && !f_s;
            st_d.pend_c = i2s && chg && f_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
    import asg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:2] ctrl,
    input  logic        ext_bclk,
    input  logic        ext_fclk,
    output logic        clk_oe,
    output logic        bclk_o,
    output logic        fclk_o,
    output logic        bit_stb,
    output logic        frame_stb,
    output logic        chan_stb,
    output logic        word16_o,
    output logic [1:0]  fmt_o
);
    localparam int DIV_W = RATIO_W;
    localparam int FRM_W = FRAME_W;

    cfg_t cfg_d, cfg_q;
    logic [DIV_W-1:0] ratio;
    logic run, clr, i2s;
    logic m_tick, m_last, b_lvl, f_lvl, m_fs, m_cs;
    logic s_tick, s_fs, s_cs;
    logic b_raw, f_raw;

    always_comb begin
        cfg_d = cfg_t'(ctrl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ratio = ratio_of(cfg_q.div);
    assign run   = cfg_q.master && (ratio != '0) && (cfg_q.flen <= FLEN_MAX);
    assign clr   = (cfg_d.div != cfg_q.div) || (cfg_d.flen != cfg_q.flen);
    assign i2s   = (cfg_q.fmt == FMT_I2S);

    asg_bitclk #(.DIV_W(DIV_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .ratio(ratio),
        .tick(m_tick), .last(m_last), .lvl(b_lvl)
    );

    asg_framer #(.FRM_W(FRM_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .tick(m_tick),
        .last(m_last), .flen(cfg_q.flen), .i2s(i2s), .lvl(f_lvl),
        .frame_stb(m_fs), .chan_stb(m_cs)
    );

    asg_slave_rx u_slave (
        .clk(clk), .rst_n(rst_n), .ext_b(ext_bclk), .ext_f(ext_fclk),
        .binv(cfg_q.binv), .finv(cfg_q.finv), .i2s(i2s),
        .tick(s_tick), .frame_stb(s_fs), .chan_stb(s_cs)
    );

    always_comb begin
        b_raw = 1'b0;
        if (run) b_raw = (ratio == DIV_W'(1)) ? clk : b_lvl;
        f_raw = run && f_lvl;
    end

    assign clk_oe    = cfg_q.master;
    assign bclk_o    = cfg_q.master && (b_raw ^ cfg_q.binv);
    assign fclk_o    = cfg_q.master && (f_raw ^ cfg_q.finv);
    assign bit_stb   = cfg_q.master ? m_tick : s_tick;
    assign frame_stb = cfg_q.master ? m_fs   : s_fs;
    assign chan_stb  = cfg_q.master ? m_cs   : s_cs;
    assign word16_o  = (cfg_q.wsz == 2'd1);
    assign fmt_o     = cfg_q.fmt;
endmodule

// File: rtl/asg_chk.sv
module asg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:2] ctrl,
    input logic        clk_oe,
    input logic        bclk_o,
    input logic        fclk_o,
    input logic        bit_stb,
    input logic        frame_stb,
    input logic        chan_stb,
    input logic [1:0]  fmt_o,
    input logic        run,
    input logic        clr,
    input logic        f_raw
);
    // R6
    stb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_stb, chan_stb}));

    // R3
    stb_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb || chan_stb) |-> bit_stb);

    // R9
    rsv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl[15]) && (($past(ctrl[12:9]) > 4'd13) || ($past(ctrl[8:6]) > 3'd4)))
        |-> (!bit_stb && !frame_stb && !chan_stb
             && bclk_o == $past(ctrl[14]) && fclk_o == $past(ctrl[13])));

    // R12
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_oe == $past(ctrl[15]));

    // R12
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_oe |-> (!bclk_o && !fclk_o));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!run || bit_stb));

    // R6
    frame_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fmt_o != 2'd0 && frame_stb) |-> !f_raw);

    // R6
    chan_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fmt_o != 2'd0 && chan_stb) |-> f_raw);
endmodule

bind aud_sclk_gen asg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .clk_oe(clk_oe),
    .bclk_o(bclk_o), .fclk_o(fclk_o), .bit_stb(bit_stb),
    .frame_stb(frame_stb), .chan_stb(chan_stb), .fmt_o(fmt_o),
    .run(run), .clr(clr), .f_raw(f_raw)
);

// File: tb/aud_sclk_gen_bench.sv
`timescale 1ns/1ps
module aud_sclk_gen_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] ctrl = '0;
    logic ext_bclk = 1'b1;
    logic ext_fclk = 1'b0;
    logic clk_oe, bclk_o, fclk_o, bit_stb, frame_stb, chan_stb, word16_o;
    logic [1:0] fmt_o;
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    aud_sclk_gen u_aud_sclk_gen (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl[15:2]),
        .ext_bclk(ext_bclk), .ext_fclk(ext_fclk), .clk_oe(clk_oe),
        .bclk_o(bclk_o), .fclk_o(fclk_o), .bit_stb(bit_stb),
        .frame_stb(frame_stb), .chan_stb(chan_stb),
        .word16_o(word16_o), .fmt_o(fmt_o)
    );

    function automatic int exp_ratio(input int code);
        case (code)
            0: return 1;   1: return 2;   2: return 4;    3: return 6;
            4: return 8;   5: return 12;  6: return 16;   7: return 24;
            8: return 32;  9: return 48;  10: return 64;  11: return 96;
            12: return 128; 13: return 192;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] mk(input bit m, input bit bi, input bit fi,
        input int dv, input int fl, input int ws, input int fm);
        return {m, bi, fi, 4'(dv), 3'(fl), 2'(ws), 2'(fm), 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Apply a master setting and compare every cycle against the model.
    task automatic run_master(input logic [15:0] c, input int maxc, input string req);
        int r, n, ncyc, bad, fk;
        logic [4:0] got, want, fgot, fwant;
        r = exp_ratio(int'(c[12:9]));
        n = 16 << c[8:6];
        ncyc = 2 * r * n + 4;
        if (ncyc > maxc) ncyc = maxc;
        bad = 0; fk = -1; fgot = '0; fwant = '0;
        @(negedge clk);
        ctrl = c;
        for (int k = 0; k < ncyc; k++) begin
            int ph, bn, off;
            bit eb, ef, es;
            @(negedge clk);
            ph  = k % r;
            bn  = (k / r) % n;
            off = (c[3:2] == 2'd0) ? 1 : 0;
            eb  = (r == 1) ? 1'b0 : (ph >= r / 2);
            ef  = (bn >= n / 2);
            es  = (ph == 0);
            want = {eb ^ c[14], ef ^ c[13], es, es && bn == off, es && bn == n/2 + off};
            got  = {bclk_o, fclk_o, bit_stb, frame_stb, chan_stb};
            if (got !== want) begin
                bad++;
                if (fk < 0) begin fk = k; fgot = got; fwant = want; end
            end
        end
        chk(bad == 0, req, $sformatf("ctrl=%h first bad cycle %0d {b,f,bit,fr,ch}", c, fk),
            longint'(fgot), longint'(fwant));
    endtask

    task automatic idle_slave();
        @(negedge clk);
        ctrl = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic reserved_idle(input logic [15:0] c, input string req);
        int bad;
        bad = 0;
        @(negedge clk);
        ctrl = c;
        @(negedge clk);
        for (int k = 0; k < 40; k++) begin
            if (bclk_o !== c[14] || fclk_o !== c[13] || bit_stb || frame_stb || chan_stb || !clk_oe)
                bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, $sformatf("reserved ctrl=%h bad cycles", c), bad, 0);
    endtask

    task automatic slave_run(input bit bi, input bit fi, input int fm, input string req);
        int nb, t, d, bad_pat, bad_out;
        nb = 40; t = 0; bad_pat = 0; bad_out = 0;
        d = (fm == 0) ? 1 : 0;
        @(negedge clk);
        ctrl = mk(0, bi, fi, 0, 0, 1, fm);
        ext_bclk = 1'b1 ^ bi;
        ext_fclk = 1'b0 ^ fi;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        fork
            begin
                for (int j = 0; j < nb; j++) begin
                    ext_bclk = 1'b0 ^ bi;
                    ext_fclk = ((j % 16) >= 8) ^ fi;
                    repeat (4) @(negedge clk);
                    ext_bclk = 1'b1 ^ bi;
                    repeat (4) @(negedge clk);
                end
            end
            begin
                for (int cy = 0; cy < nb * 8 + 9; cy++) begin
                    bit efs, ecs;
                    @(negedge clk);
                    if (clk_oe || bclk_o || fclk_o) bad_out++;
                    if (bit_stb) begin
                        efs = (t - d >= 16) && ((t - d) % 16 == 0);
                        ecs = (t - d >= 8) && ((t - d) % 16 == 8);
                        if (frame_stb !== efs || chan_stb !== ecs) bad_pat++;
                        t++;
                    end else if (frame_stb || chan_stb) begin
                        bad_pat++;
                    end
                end
            end
        join
        chk(t == nb, "R11", "slave bit strobes", t, nb);
        chk(bad_pat == 0, req, $sformatf("slave strobe pattern fmt=%0d", fm), bad_pat, 0);
        chk(bad_out == 0, "R12", "slave clock outputs quiet", bad_out, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", "run did not finish", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        repeat (4) @(negedge clk);
        chk({clk_oe, bclk_o, fclk_o, bit_stb, frame_stb, chan_stb} == 6'd0,
            "R1", "outputs in reset", {clk_oe, bclk_o, fclk_o, bit_stb, frame_stb, chan_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({clk_oe, bclk_o, fclk_o, bit_stb, frame_stb, chan_stb} == 6'd0,
            "R1", "outputs after reset", {clk_oe, bclk_o, fclk_o, bit_stb, frame_stb, chan_stb}, 0);

        // R2 decoded settings
        ctrl = mk(0, 0, 0, 0, 0, 1, 2);
        @(negedge clk);
        chk(word16_o == 1'b1, "R2", "word16 for code 1", word16_o, 1);
        chk(fmt_o == 2'd2, "R2", "format field", fmt_o, 2);
        ctrl = mk(0, 0, 0, 0, 0, 2, 3);
        @(negedge clk);
        chk(word16_o == 1'b0, "R2", "word16 for code 2", word16_o, 0);
        // R12 output enable
        ctrl = mk(1, 0, 0, 4, 0, 1, 1);
        @(negedge clk);
        chk(clk_oe == 1'b1, "R12", "clk_oe in master", clk_oe, 1);
        idle_slave();

        // Directed master cases
        run_master(mk(1, 0, 0, 5, 0, 1, 1), 3000, "R3");
        idle_slave();
        run_master(mk(1, 0, 0, 1, 4, 1, 2), 3000, "R5");
        idle_slave();
        run_master(mk(1, 0, 0, 3, 1, 1, 0), 3000, "R7");
        idle_slave();
        run_master(mk(1, 1, 0, 2, 0, 1, 3), 3000, "R8");
        idle_slave();
        run_master(mk(1, 0, 1, 2, 0, 1, 1), 3000, "R8");
        idle_slave();
        run_master(mk(1, 0, 0, 0, 0, 1, 1), 200, "R4");
        @(posedge clk);
        #5;
        chk(bclk_o == 1'b1, "R4", "bit clock high with module clock", bclk_o, 1);
        idle_slave();
        run_master(mk(1, 1, 0, 0, 1, 1, 0), 200, "R4");
        idle_slave();

        // R10 restart on field change without passing through slave
        run_master(mk(1, 0, 0, 2, 0, 1, 1), 37, "R10");
        run_master(mk(1, 0, 0, 3, 0, 1, 1), 400, "R10");
        run_master(mk(1, 0, 0, 3, 2, 1, 0), 1000, "R10");
        idle_slave();

        // R9 reserved codes
        reserved_idle(mk(1, 0, 0, 14, 0, 1, 1), "R9");
        reserved_idle(mk(1, 1, 1, 15, 1, 1, 0), "R9");
        reserved_idle(mk(1, 1, 0, 2, 5, 1, 1), "R9");
        reserved_idle(mk(1, 0, 1, 4, 7, 1, 2), "R9");
        idle_slave();

        // Random master configurations
        for (int i = 0; i < 16; i++) begin
            int dv, fl, fm;
            bit bi, fi;
            dv = $urandom_range(0, 13);
            fl = $urandom_range(0, 4);
            fm = $urandom_range(0, 3);
            bi = 1'($urandom_range(0, 1));
            fi = 1'($urandom_range(0, 1));
            run_master(mk(1, bi, fi, dv, fl, $urandom_range(0, 3), fm), 3000,
                       (fm == 0) ? "R7" : "R6");
            idle_slave();
        end

        // Slave mode
        slave_run(0, 0, 1, "R11");
        slave_run(1, 1, 0, "R11");
        slave_run(0, 1, 2, "R11");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule